// File: doc/BRIEF.md
# Slave Serial-Audio Slot Transmitter

This block sends one stereo pair of 20-bit PCM samples per audio frame on a single serial data line. The bit clock and the frame clock both come from outside, so the block is always a slave. It over-samples both clocks with its own system clock, finds their edges, counts bit times from the frame edge, and drives an assigned 32-bit slot position. All other bit times are released, with the output-enable low. A three-bit mode input chooses between two framings. The first is a two-channel word-select framing with one slot per half. The second is a multi-slot time-division framing, in which the block drives one chosen adjacent pair of slots.

Samples enter through a valid/ready stream port backed by a one-entry holding register. A pair is accepted in any cycle where both valid and ready are high. Ready is low while the holding register is full, and an upstream source must hold its data until ready returns. At each frame start the held pair moves into the frame registers, so a frame never mixes two sample pairs. If no pair is waiting at that moment, the frame carries zeros.

Top module: `sts_slot_serializer`

## Requirements
- R1: `mode_i` encodes the framing. 0 selects word-select (I2S) framing. 1, 2, 3 and 4 select TDM with the driven slots 0–1, 2–3, 4–5 or 6–7 (zero-based), respectively. The values 5, 6 and 7 never enable the output.
- R2: A driven slot carries its 20-bit sample MSB first, one bit per bit-clock period. The MSB is in the bit period that follows the one in which the frame-clock edge was seen. Outputs change only after a falling bit-clock edge.
- R3: `sdata_oe_o` is low in every bit time outside the assigned slots, and `sdata_o` is 0 whenever `sdata_oe_o` is low.
- R4: Left data goes in the first slot of the selected TDM pair and right data in the second. In I2S mode, left is sent while the frame clock is low and right while it is high.
- R5: The 12 bit times that follow the 20 data bits in a driven slot are driven as 0, with `sdata_oe_o` high.
- R6: In TDM mode a rising frame-clock edge starts slot 0. The frame length in slots (2, 4 or 8) follows from the number of bit clocks between rising edges.
- R7: In I2S mode each frame-clock half holds one 32-bit slot. When a half is longer than 32 bit clocks, the output is released for the remainder of the half.
- R8: The pair in the holding register is latched at a frame start: the rising frame-clock edge in TDM mode, the falling one in I2S mode. With no pair waiting, the frame sends zeros.
- R9: `in_ready_o` is high exactly when the holding register is empty. A pair is taken when valid and ready are both high. A pair offered while ready is low is not taken.
- R10: After reset `sdata_oe_o` is low, `sdata_o` is 0 and `in_ready_o` is high. Nothing is driven until the first frame start after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that over-samples the serial clocks |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 3 | Framing and slot-pair select (R1) |
| bclk_i | input | 1 | External bit clock |
| lrclk_i | input | 1 | External word-select / frame-sync clock |
| in_valid_i | input | 1 | Sample pair valid |
| in_ready_o | output | 1 | Holding register empty |
| in_left_i | input | 20 | Left sample |
| in_right_i | input | 20 | Right sample |
| sdata_o | output | 1 | Serial data |
| sdata_oe_o | output | 1 | Serial data output enable |

## Verification
The hardest situations to reach are those that depend on where a frame-sync edge falls relative to the slot count. One is the bit period that opens a frame, which still carries the last bit time of the previous frame and is driven only when the chosen pair ends the frame. Another is a half or frame longer than the driven slots, after which the line must stay released. The stimulus reaches these cases by driving the bit and frame clocks directly at several ratios: word-select halves of 32 and 64, and time-division frames of 2, 4 and 8 slots. It checks every bit period, including the opening one, against a model of the counter. For back-pressure, a second pair is offered in the same frame as the first, so it finds the holding register full. The following frame then shows which pair was kept.

// File: rtl/sts_pkg.sv
package sts_pkg;
  localparam int unsigned FMT_I2S = 0;

  typedef enum logic {
    CH_LEFT  = 1'b0,
    CH_RIGHT = 1'b1
  } chan_e;
endpackage

// File: rtl/sts_pin_sync.sv
module sts_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_i,
  input  logic lrclk_i,
  output logic bclk_rise,
  output logic bclk_fall,
  output logic lrclk_lvl
);
  // bit clock needs one extra stage for edge detection
  logic [STAGES:0]   bclk_q;
  logic [STAGES-1:0] lrclk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk_q  <= '1;
      lrclk_q <= '0;
    end else begin
      bclk_q  <= {bclk_q[STAGES-1:0], bclk_i};
      lrclk_q <= {lrclk_q[STAGES-2:0], lrclk_i};
    end
  end

  assign bclk_rise = bclk_q[STAGES-1] & ~bclk_q[STAGES];
  assign bclk_fall = ~bclk_q[STAGES-1] & bclk_q[STAGES];
  assign lrclk_lvl = lrclk_q[STAGES-1];
endmodule

// File: rtl/sts_frame_timer.sv
module sts_frame_timer #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_evt,
  input  logic             lr_lvl,
  input  logic             i2s_mode,
  output logic [CNT_W-1:0] cnt,
  output logic             chan,
  output logic             locked,
  output logic             frame_start
);
  logic primed;
  logic lr_prev;
  logic boundary;
  logic start_edge;

  always_comb begin
    if (i2s_mode) begin
      boundary   = lr_lvl ^ lr_prev;
      start_edge = lr_prev & ~lr_lvl;
    end else begin
      boundary   = lr_lvl & ~lr_prev;
      start_edge = lr_lvl & ~lr_prev;
    end
  end

  assign frame_start = rise_evt & primed & start_edge;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '1;
      primed  <= 1'b0;
      lr_prev <= 1'b0;
      chan    <= 1'b0;
      locked  <= 1'b0;
    end else if (rise_evt) begin
      primed  <= 1'b1;
      lr_prev <= lr_lvl;
      if (primed) begin
        chan <= lr_lvl;
        if (boundary)       cnt <= '0;
        else if (cnt != '1) cnt <= cnt + 1'b1;
        if (start_edge)     locked <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sts_slot_shifter.sv
module sts_slot_shifter #(
  parameter int SAMPLE_W = 20,
  parameter int BIT_W    = 5,
  parameter int CNT_W    = 9,
  parameter int MODE_W   = 3,
  parameter int PAIRS    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fall_evt,
  input  logic [CNT_W-1:0]    cnt,
  input  logic                chan,
  input  logic                locked,
  input  logic [MODE_W-1:0]   mode,
  input  logic [SAMPLE_W-1:0] word_l,
  input  logic [SAMPLE_W-1:0] word_r,
  output logic                sdata,
  output logic                sdata_oe
);
  import sts_pkg::*;
  localparam int SLOT_W = CNT_W - BIT_W;

  logic [SLOT_W-1:0]   slot;
  logic [BIT_W-1:0]    bitpos;
  logic                drive;
  logic                sel_right;
  logic [SAMPLE_W-1:0] word;
  logic [SAMPLE_W-1:0] shreg;

  assign slot   = cnt[CNT_W-1:BIT_W];
  assign bitpos = cnt[BIT_W-1:0];

  always_comb begin
    drive     = 1'b0;
    sel_right = 1'b0;
    if (locked) begin
      if (int'(mode) == FMT_I2S) begin
        drive     = (slot == '0);
        sel_right = chan;
      end else if (int'(mode) <= PAIRS) begin
        if (int'(slot) == 2 * (int'(mode) - 1)) begin
          drive = 1'b1;
        end else if (int'(slot) == 2 * int'(mode) - 1) begin
          drive     = 1'b1;
          sel_right = 1'b1;
        end
      end
    end
  end

  assign word = sel_right ? word_r : word_l;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sdata    <= 1'b0;
      sdata_oe <= 1'b0;
      shreg    <= '0;
    end else if (fall_evt) begin
      sdata_oe <= drive;
      if (!drive) begin
        sdata <= 1'b0;
      end else if (bitpos == '0) begin
        sdata <= word[SAMPLE_W-1];
        shreg <= {word[SAMPLE_W-2:0], 1'b0};
      end else begin
        sdata <= shreg[SAMPLE_W-1];
        shreg <= {shreg[SAMPLE_W-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/sts_slot_serializer.sv
module sts_slot_serializer #(
  parameter int SAMPLE_W    = 20,
  parameter int SLOT_LEN    = 32,
  parameter int MAX_SLOTS   = 8,
  parameter int SYNC_STAGES = 2,
  parameter int MODE_W      = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [MODE_W-1:0]   mode_i,
  input  logic                bclk_i,
  input  logic                lrclk_i,
  input  logic                in_valid_i,
  output logic                in_ready_o,
  input  logic [SAMPLE_W-1:0] in_left_i,
  input  logic [SAMPLE_W-1:0] in_right_i,
  output logic                sdata_o,
  output logic                sdata_oe_o
);
  import sts_pkg::*;
  localparam int BIT_W = $clog2(SLOT_LEN);
  localparam int CNT_W = $clog2(SLOT_LEN * MAX_SLOTS) + 1;
  localparam int PAIRS = MAX_SLOTS / 2;

  logic                bclk_rise, bclk_fall, lr_lvl;
  logic                i2s_mode;
  logic [CNT_W-1:0]    cnt;
  logic                chan, locked, frame_start;
  logic                buf_full;
  logic [SAMPLE_W-1:0] buf_l, buf_r, cur_l, cur_r;
  logic                take;

  assign i2s_mode   = (int'(mode_i) == FMT_I2S);
  assign in_ready_o = ~buf_full;
  assign take       = in_valid_i & ~buf_full;

  sts_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk_i), .lrclk_i(lrclk_i),
    .bclk_rise(bclk_rise), .bclk_fall(bclk_fall), .lrclk_lvl(lr_lvl)
  );

  sts_frame_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .rise_evt(bclk_rise), .lr_lvl(lr_lvl),
    .i2s_mode(i2s_mode), .cnt(cnt), .chan(chan), .locked(locked),
    .frame_start(frame_start)
  );

  // one-entry holding register and per-frame sample registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_full <= 1'b0;
      buf_l    <= '0;
      buf_r    <= '0;
      cur_l    <= '0;
      cur_r    <= '0;
    end else begin
      if (frame_start) begin
        cur_l <= buf_full ? buf_l : '0;
        cur_r <= buf_full ? buf_r : '0;
      end
      if (take) begin
        buf_l    <= in_left_i;
        buf_r    <= in_right_i;
        buf_full <= 1'b1;
      end else if (frame_start) begin
        buf_full <= 1'b0;
      end
    end
  end

  sts_slot_shifter #(
    .SAMPLE_W(SAMPLE_W), .BIT_W(BIT_W), .CNT_W(CNT_W),
    .MODE_W(MODE_W), .PAIRS(PAIRS)
  ) u_shift (
    .clk(clk), .rst_n(rst_n), .fall_evt(bclk_fall), .cnt(cnt),
    .chan(chan), .locked(locked), .mode(mode_i),
    .word_l(cur_l), .word_r(cur_r),
    .sdata(sdata_o), .sdata_oe(sdata_oe_o)
  );
endmodule

// File: rtl/sts_slot_serializer_chk.sv
module sts_slot_serializer_chk #(
  parameter int CNT_W  = 9,
  parameter int MODE_W = 3,
  parameter int PAIRS  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [MODE_W-1:0] mode_i,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic              sdata_o,
  input logic              sdata_oe_o,
  input logic              bclk_fall,
  input logic              frame_start,
  input logic              locked,
  input logic [CNT_W-1:0]  cnt
);
  AST_RELEASED_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !sdata_oe_o |-> !sdata_o);  // R3

  AST_CHANGE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !bclk_fall |=> ($stable(sdata_o) && $stable(sdata_oe_o)));  // R2

  AST_FULL_BLOCKS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && in_ready_o) |=> !in_ready_o);  // R9

  AST_QUIET_UNTIL_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |=> !sdata_oe_o);  // R10

  AST_BAD_MODE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    ((int'(mode_i) > PAIRS) && bclk_fall) |=> !sdata_oe_o);  // R1

  AST_START_CLEARS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (cnt == '0));  // R6
endmodule

bind sts_slot_serializer sts_slot_serializer_chk #(
  .CNT_W(CNT_W), .MODE_W(MODE_W), .PAIRS(PAIRS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .in_valid_i(in_valid_i),
  .in_ready_o(in_ready_o), .sdata_o(sdata_o), .sdata_oe_o(sdata_oe_o),
  .bclk_fall(bclk_fall), .frame_start(frame_start), .locked(locked),
  .cnt(cnt)
);

// File: tb/sts_slot_serializer_tb.sv
module sts_slot_serializer_tb;
  localparam int SW   = 20;
  localparam int CMAX = 511;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    mode = 3'd0;
  logic          bclk = 1'b1;
  logic          lrclk = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [SW-1:0] in_l = '0, in_r = '0;
  logic          sdata, sdata_oe;

  int    checks = 0;
  int    errors = 0;
  string off_tag = "R3";

  // reference model state
  int          mcnt, mode_v;
  bit          mprimed, mlrp, mlocked, mchan, mbuf_full;
  bit [SW-1:0] mbuf_l, mbuf_r, mcur_l, mcur_r;

  always #10 clk = ~clk;

  sts_slot_serializer u_dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .bclk_i(bclk), .lrclk_i(lrclk),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_left_i(in_l),
    .in_right_i(in_r), .sdata_o(sdata), .sdata_oe_o(sdata_oe)
  );

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic reset_dut(int m);
    @(negedge clk);
    rst_n = 1'b0; bclk = 1'b1; lrclk = 1'b0; in_valid = 1'b0; mode = 3'(m);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    mode_v = m; mcnt = CMAX; mprimed = 0; mlrp = 0; mlocked = 0; mchan = 0;
    mbuf_full = 0; mbuf_l = '0; mbuf_r = '0; mcur_l = '0; mcur_r = '0;
  endtask

  task automatic model_rise(bit lr);
    bit bnd, fst;
    if (!mprimed) begin
      mprimed = 1; mlrp = lr;
      return;
    end
    bnd = (mode_v == 0) ? (lr != mlrp) : (lr && !mlrp);
    fst = (mode_v == 0) ? (mlrp && !lr) : (lr && !mlrp);
    if (bnd) mcnt = 0;
    else if (mcnt != CMAX) mcnt++;
    if (fst) begin
      mlocked = 1;
      mcur_l = mbuf_full ? mbuf_l : '0;
      mcur_r = mbuf_full ? mbuf_r : '0;
      mbuf_full = 0;
    end
    mchan = lr; mlrp = lr;
  endtask

  task automatic try_push(logic [SW-1:0] pl, logic [SW-1:0] pr);
    check(in_ready == !mbuf_full, "R9", "in_ready", int'(in_ready), int'(!mbuf_full));
    if (in_ready) begin
      in_valid = 1'b1; in_l = pl; in_r = pr;
      @(negedge clk);
      in_valid = 1'b0;
      mbuf_full = 1; mbuf_l = pl; mbuf_r = pr;
    end else begin
      in_valid = 1'b1; in_l = ~pl; in_r = ~pr;
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // one bit-clock period: fall, settle, sample, rise
  task automatic bclk_cycle(bit lr, bit push, logic [SW-1:0] pl, logic [SW-1:0] pr, string tag);
    int slot, bitp;
    bit drive, selr, ed;
    bit [SW-1:0] w;
    string t;
    @(negedge clk);
    bclk = 1'b0; lrclk = lr;
    if (push) begin
      try_push(pl, pr);
      repeat (6) @(negedge clk);
    end else begin
      repeat (7) @(negedge clk);
    end
    slot = mcnt / 32; bitp = mcnt % 32; drive = 0; selr = 0;
    if (mlocked) begin
      if (mode_v == 0) begin
        drive = (slot == 0); selr = mchan;
      end else if (mode_v >= 1 && mode_v <= 4) begin
        if (slot == 2 * (mode_v - 1)) drive = 1;
        else if (slot == 2 * mode_v - 1) begin drive = 1; selr = 1; end
      end
    end
    w  = selr ? mcur_r : mcur_l;
    ed = (drive && bitp < SW) ? w[SW-1-bitp] : 1'b0;
    if (!drive) t = off_tag;
    else if (bitp >= SW) t = "R5";
    else t = tag;
    check(sdata_oe == drive, t, "sdata_oe", int'(sdata_oe), int'(drive));
    check(sdata == ed, t, "sdata", int'(sdata), int'(ed));
    @(negedge clk);
    bclk = 1'b1;
    model_rise(lr);
    repeat (7) @(negedge clk);
  endtask

  task automatic prime(bit i2s, bit push, logic [SW-1:0] pl, logic [SW-1:0] pr);
    string keep = off_tag;
    off_tag = "R10";
    for (int k = 0; k < 8; k++)
      bclk_cycle((i2s && k >= 4), (push && k == 1), pl, pr, "R10");
    off_tag = keep;
  endtask

  task automatic i2s_frame(int half, bit push, logic [SW-1:0] pl, logic [SW-1:0] pr, string tag);
    for (int k = 0; k < 2 * half; k++)
      bclk_cycle((k >= half), (push && k == 3), pl, pr, tag);
  endtask

  task automatic tdm_frame(int nslots, bit push, logic [SW-1:0] pl, logic [SW-1:0] pr,
                           bit push2, logic [SW-1:0] ql, logic [SW-1:0] qr, string tag);
    for (int k = 0; k < nslots * 32; k++) begin
      if (push2 && k == 6) bclk_cycle((k == 0), 1'b1, ql, qr, tag);
      else bclk_cycle((k == 0), (push && k == 3), pl, pr, tag);
    end
  endtask

  task automatic t_reset;  // R10
    reset_dut(0);
    @(negedge clk);
    check(sdata_oe == 1'b0, "R10", "oe after reset", int'(sdata_oe), 0);
    check(sdata == 1'b0, "R10", "sdata after reset", int'(sdata), 0);
    check(in_ready == 1'b1, "R10", "ready after reset", int'(in_ready), 1);
  endtask

  task automatic t_i2s_basic;  // R2 R4
    reset_dut(0);
    prime(1, 1, 20'hA5C3E, 20'h3C5A1);
    i2s_frame(32, 1, 20'h80001, 20'h7FFFE, "R2");
    i2s_frame(32, 1, 20'hFFFFF, 20'h00000, "R4");
    i2s_frame(32, 0, '0, '0, "R2");
  endtask

  task automatic t_i2s_long_half;  // R7
    reset_dut(0);
    prime(1, 1, 20'h12345, 20'hEDCBA);
    i2s_frame(64, 1, 20'hC0FFE, 20'h0BEEF, "R7");
    i2s_frame(64, 0, '0, '0, "R7");
  endtask

  task automatic t_tdm_pairs;  // R4 R3
    for (int m = 1; m <= 4; m++) begin
      reset_dut(m);
      prime(0, 1, 20'h9F0C3 ^ 20'(m), 20'h60F3C ^ 20'(m << 4));
      tdm_frame(8, 1, 20'hB1E55, 20'h4AA55, 0, '0, '0, "R4");
      tdm_frame(8, 0, '0, '0, 0, '0, '0, "R4");
    end
  endtask

  task automatic t_tdm_short;  // R6
    reset_dut(1);
    prime(0, 1, 20'h55555, 20'hAAAAA);
    tdm_frame(2, 1, 20'h0F0F0, 20'hF0F0F, 0, '0, '0, "R6");
    tdm_frame(2, 0, '0, '0, 0, '0, '0, "R6");
    reset_dut(2);
    prime(0, 1, 20'h13579, 20'h2468A);
    tdm_frame(4, 1, 20'hFEDCB, 20'h01234, 0, '0, '0, "R6");
    tdm_frame(4, 0, '0, '0, 0, '0, '0, "R6");
  endtask

  task automatic t_underrun;  // R8
    reset_dut(1);
    prime(0, 0, '0, '0);
    tdm_frame(2, 0, '0, '0, 0, '0, '0, "R8");
    tdm_frame(2, 1, 20'hABCDE, 20'h54321, 0, '0, '0, "R8");
    tdm_frame(2, 0, '0, '0, 0, '0, '0, "R8");
    tdm_frame(2, 0, '0, '0, 0, '0, '0, "R8");
  endtask

  task automatic t_backpressure;  // R9
    reset_dut(1);
    prime(0, 0, '0, '0);
    tdm_frame(2, 1, 20'h6DB6D, 20'h92492, 1, 20'h11111, 20'h22222, "R9");
    tdm_frame(2, 0, '0, '0, 0, '0, '0, "R9");
  endtask

  task automatic t_bad_mode;  // R1
    off_tag = "R1";
    reset_dut(5);
    prime(0, 1, 20'hFFFFF, 20'hFFFFF);
    tdm_frame(8, 0, '0, '0, 0, '0, '0, "R1");
    reset_dut(7);
    prime(0, 1, 20'hFFFFF, 20'hFFFFF);
    tdm_frame(2, 0, '0, '0, 0, '0, '0, "R1");
    off_tag = "R3";
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired: actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_i2s_basic();
    t_i2s_long_half();
    t_tdm_pairs();
    t_tdm_short();
    t_underrun();
    t_backpressure();
    t_bad_mode();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule